// File: doc/BRIEF.md
# Hardware Standby Sequencing Controller

This block is the power-mode sequencer of a small microcontroller. It watches two active-low board pins, a standby request and a reset request. From them it decides when the chip is running, when it is parked in hardware standby with its I/O floating and its clock stopped, and when it is coming back up. Bringing the chip back up happens in a fixed order: the oscillator starts, a counted settling interval elapses, the reset pin is released, a reset exception phase runs, and then program execution begins.

Pulling the standby pin low parks the chip at once from any state. On that entry the block captures the RAM-enable control bit, which decides whether on-chip RAM contents may be trusted afterwards. It also captures the three mode pins. If the mode pins move while the chip is parked, a sticky flag is raised. A second sticky flag records a reset release that came before the oscillator had settled. The two pins pass through two-flop synchronizers. The register-sourced inputs (RAM-enable bit, mode pins) are sampled directly on the clock.

Top module: `hw_stby_seq`

## Requirements
- R1: A change on either pin takes effect on the third rising clock edge after it is driven. The state does not change at the second edge.
- R2: A low standby pin moves the block to standby from every state. The state code 0 is settle=1, ready=2, except=3, exec=4. In standby, `io_hiz`=1, `func_rst`=1 and `osc_en`=0.
- R3: On the clock edge that enters standby, `ram_keep` takes the inverse of `ram_en`. It then holds that value until the next standby entry, whatever `ram_en` does. After `rst` it is 0.
- R4: In standby, any difference between `mode_pins` and the value captured at entry sets `mode_viol` on the next edge. The flag stays set until `rst`. Mode changes outside standby do not set it.
- R5: When the standby pin goes high, the block leaves standby for the settle state (code 1) with `osc_en`=1 and `func_rst`=1, whatever the reset pin level.
- R6: The settle state lasts exactly `STAB_CYC` clock cycles and is then followed by the ready state (code 2). The settle count restarts from zero at each standby exit and after `rst`.
- R7: A reset release seen in the ready state starts the except state (code 3), which lasts exactly `EXC_CYC` cycles and is followed by exec (code 4). `func_rst` is 0 in both except and exec.
- R8: A reset release seen during settle sets the sticky `early_rel` flag. The block then stays in reset, and a new low-then-high on the reset pin is needed to leave ready.
- R9: A reset release counts only if the reset pin was seen low after the last standby or the last consumed release. Leaving standby with the reset pin already high therefore ends in ready, not except.
- R10: A low reset pin during exec returns the block to ready (code 2) with `func_rst`=1 and no new settle interval. A later release goes straight to except.
- R11: After `rst` the block is in settle with `osc_en`=1, `func_rst`=1, `io_hiz`=0, and `early_rel`, `mode_viol` and `ram_keep` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_pin_n | input | 1 | Standby request pin, active low, asynchronous |
| res_pin_n | input | 1 | Reset request pin, active low, asynchronous |
| ram_en | input | 1 | RAM-enable control bit, sampled on standby entry |
| mode_pins | input | 3 | Mode pins, captured on entry and watched during standby |
| func_rst | output | 1 | Global functional reset to the rest of the chip |
| io_hiz | output | 1 | Puts the I/O pads in high impedance |
| osc_en | output | 1 | Oscillator enable |
| ram_keep | output | 1 | RAM contents retained through the last standby |
| state_o | output | 3 | Current state code (see R2) |
| mode_viol | output | 1 | Sticky: mode pins moved during standby |
| early_rel | output | 1 | Sticky: reset released before settling completed |

## Verification
The bench sweeps the release moment across every cycle of the settle window and past it. A design with an off-by-one settle count or a wrong synchronizer depth would then flag the wrong boundary release as early, or send it to except too soon. The bench enters standby from each of the four other states, with both values of the RAM-enable bit. A design that sampled that bit continuously, rather than once at entry, would let `ram_keep` follow the later toggle. All 64 pairs of captured and disturbed mode values are tried, so a flag that ignored one bit or cleared itself would show up. The bench also leaves standby with the reset pin already high and takes the reset pin low during exec, which catches a design that treats a level as a release, or that re-runs settling after a warm reset.

// File: rtl/hw_stby_pkg.sv
package hw_stby_pkg;

    typedef enum logic [2:0] {
        PM_STANDBY = 3'd0,
        PM_SETTLE  = 3'd1,
        PM_READY   = 3'd2,
        PM_EXCEPT  = 3'd3,
        PM_EXEC    = 3'd4
    } pm_state_e;

    typedef struct packed {
        logic stby_n;
        logic res_n;
    } pin_pair_t;

    localparam int MODE_W = 3;

    function automatic logic holds_reset(pm_state_e s);
        return (s == PM_STANDBY) || (s == PM_SETTLE) || (s == PM_READY);
    endfunction

endpackage

// File: rtl/hw_stby_sync.sv
module hw_stby_sync #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        logic stab;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= RST_VAL[i];
                stab <= RST_VAL[i];
            end else begin
                meta <= d[i];
                stab <= meta;
            end
        end
        assign q[i] = stab;
    end
endmodule

// File: rtl/hw_stby_timer.sv
module hw_stby_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && !done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hw_stby_seq.sv
module hw_stby_seq
    import hw_stby_pkg::*;
#(
    parameter int STAB_CYC = 1024,
    parameter int EXC_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stby_pin_n,
    input  logic              res_pin_n,
    input  logic              ram_en,
    input  logic [MODE_W-1:0] mode_pins,
    output logic              func_rst,
    output logic              io_hiz,
    output logic              osc_en,
    output logic              ram_keep,
    output logic [2:0]        state_o,
    output logic              mode_viol,
    output logic              early_rel
);
    pin_pair_t          pins;
    pm_state_e          state, nxt;
    logic               seen_low;
    logic               settle_done, exc_done;
    logic               release_ev, early_ev, enter_ev;
    logic [MODE_W-1:0]  mode_cap;

    hw_stby_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({stby_pin_n, res_pin_n}),
        .q   (pins)
    );

    hw_stby_timer #(.LIMIT(STAB_CYC)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .clr  (state == PM_STANDBY),
        .en   (state == PM_SETTLE),
        .done (settle_done)
    );

    hw_stby_timer #(.LIMIT(EXC_CYC)) u_except (
        .clk  (clk),
        .rst  (rst),
        .clr  (state != PM_EXCEPT),
        .en   (state == PM_EXCEPT),
        .done (exc_done)
    );

    assign release_ev = pins.res_n && seen_low;
    assign enter_ev   = !pins.stby_n && (state != PM_STANDBY);
    assign early_ev   = pins.stby_n && (state == PM_SETTLE) && release_ev;

    always_comb begin
        nxt = state;
        if (!pins.stby_n) begin
            nxt = PM_STANDBY;
        end else begin
            unique case (state)
                PM_STANDBY: nxt = PM_SETTLE;
                PM_SETTLE:  if (settle_done) nxt = PM_READY;
                PM_READY:   if (release_ev)  nxt = PM_EXCEPT;
                PM_EXCEPT:  if (exc_done)    nxt = PM_EXEC;
                PM_EXEC:    if (!pins.res_n) nxt = PM_READY;
                default:    nxt = PM_STANDBY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PM_SETTLE;
            seen_low  <= 1'b0;
            ram_keep  <= 1'b0;
            mode_cap  <= '0;
            mode_viol <= 1'b0;
            early_rel <= 1'b0;
        end else begin
            state <= nxt;
            if (!pins.res_n) begin
                seen_low <= 1'b1;
            end else if (early_ev || state == PM_STANDBY || !pins.stby_n ||
                         (state == PM_READY && nxt == PM_EXCEPT)) begin
                seen_low <= 1'b0;
            end
            if (enter_ev) begin
                ram_keep <= !ram_en;
                mode_cap <= mode_pins;
            end
            if (state == PM_STANDBY && mode_pins != mode_cap) begin
                mode_viol <= 1'b1;
            end
            if (early_ev) begin
                early_rel <= 1'b1;
            end
        end
    end

    assign func_rst = holds_reset(state);
    assign io_hiz   = (state == PM_STANDBY);
    assign osc_en   = (state != PM_STANDBY);
    assign state_o  = state;
endmodule

// File: rtl/hw_stby_chk.sv
module hw_stby_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] state_o,
    input logic       func_rst,
    input logic       io_hiz,
    input logic       osc_en,
    input logic       ram_keep,
    input logic       mode_viol,
    input logic       early_rel
);
    p_hiz_parked_r2: assert property (@(posedge clk) disable iff (rst)
        io_hiz |-> (func_rst && !osc_en));

    p_ram_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0 && $past(state_o) == 3'd0) |-> $stable(ram_keep));

    p_mode_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        $past(mode_viol) |-> mode_viol);

    p_exit_to_settle_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) == 3'd0 && state_o != 3'd0) |-> (state_o == 3'd1 && osc_en));

    p_except_from_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3 && $past(state_o) != 3'd3) |-> ($past(state_o) == 3'd2));

    p_exec_from_except_r7: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 && $past(state_o) != 3'd4) |-> ($past(state_o) == 3'd3));

    p_early_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        $past(early_rel) |-> early_rel);
endmodule

bind hw_stby_seq hw_stby_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .state_o   (state_o),
    .func_rst  (func_rst),
    .io_hiz    (io_hiz),
    .osc_en    (osc_en),
    .ram_keep  (ram_keep),
    .mode_viol (mode_viol),
    .early_rel (early_rel)
);

// File: tb/hw_stby_seq_bench.sv
`timescale 1ns/1ps
module hw_stby_seq_bench;
    localparam int STAB = 8;
    localparam int EXC  = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stby_n = 1'b1;
    logic       res_n = 1'b0;
    logic       ram_en = 1'b1;
    logic [2:0] mode = 3'd0;
    logic       func_rst, io_hiz, osc_en, ram_keep, mode_viol, early_rel;
    logic [2:0] state;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    hw_stby_seq #(.STAB_CYC(STAB), .EXC_CYC(EXC)) u_hw_stby_seq (
        .clk        (clk),
        .rst        (rst),
        .stby_pin_n (stby_n),
        .res_pin_n  (res_n),
        .ram_en     (ram_en),
        .mode_pins  (mode),
        .func_rst   (func_rst),
        .io_hiz     (io_hiz),
        .osc_en     (osc_en),
        .ram_keep   (ram_keep),
        .state_o    (state),
        .mode_viol  (mode_viol),
        .early_rel  (early_rel)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset, then optionally walk forward to state s (1..4); ends at a negedge.
    task automatic reach(input int s, input logic [2:0] m);
        @(negedge clk);
        rst = 1'b1; stby_n = 1'b1; res_n = 1'b0; ram_en = 1'b1; mode = m;
        step(3);
        rst = 1'b0;
        if (s >= 2) step(STAB);
        if (s >= 3) begin res_n = 1'b1; step(3); end
        if (s >= 4) step(EXC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R11 reset state
        reach(1, 3'd5);
        chk("R11 state", state, 1);
        chk("R11 osc_en", osc_en, 1);
        chk("R11 func_rst", func_rst, 1);
        chk("R11 io_hiz", io_hiz, 0);
        chk("R11 early_rel", early_rel, 0);
        chk("R11 mode_viol", mode_viol, 0);
        chk("R11 ram_keep", ram_keep, 0);
        // R6 settle length after reset
        step(STAB - 1);
        chk("R6 still settle", state, 1);
        step(1);
        chk("R6 ready", state, 2);
        // R1 / R7 release path
        res_n = 1'b1;
        step(2);
        chk("R1 no change at 2nd edge", state, 2);
        step(1);
        chk("R7 except", state, 3);
        chk("R7 func_rst low", func_rst, 0);
        step(EXC - 1);
        chk("R7 except length", state, 3);
        step(1);
        chk("R7 exec", state, 4);
        chk("R7 exec func_rst", func_rst, 0);

        // R2 / R3 entry from each state with both ram_en values
        for (int s = 1; s <= 4; s++) begin
            for (int r = 0; r < 2; r++) begin
                reach(s, 3'd2);
                ram_en = r[0];
                stby_n = 1'b0;
                step(2);
                chk("R1 entry not at 2nd edge", state, s);
                step(1);
                chk("R2 standby state", state, 0);
                chk("R2 io_hiz", io_hiz, 1);
                chk("R2 osc_en", osc_en, 0);
                chk("R2 func_rst", func_rst, 1);
                chk("R3 ram_keep at entry", ram_keep, (r == 0) ? 1 : 0);
                ram_en = ~r[0];
                step(3);
                chk("R3 ram_keep held", ram_keep, (r == 0) ? 1 : 0);
                // R5 exit with reset low
                stby_n = 1'b1;
                step(3);
                chk("R5 settle", state, 1);
                chk("R5 osc_en", osc_en, 1);
                chk("R5 func_rst", func_rst, 1);
                chk("R3 ram_keep after exit", ram_keep, (r == 0) ? 1 : 0);
                step(STAB - 1);
                chk("R6 settle length", state, 1);
                step(1);
                chk("R6 ready after settle", state, 2);
            end
        end

        // R4 mode sweep
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 8; d++) begin
                reach(2, 3'(~m));
                mode = 3'(m);
                step(1);
                chk("R4 no flag outside standby", mode_viol, 0);
                stby_n = 1'b0;
                step(3);
                mode = 3'(m ^ d);
                step(1);
                chk("R4 flag on change", mode_viol, (d != 0) ? 1 : 0);
                mode = 3'(m);
                step(1);
                chk("R4 flag sticky", mode_viol, (d != 0) ? 1 : 0);
            end
        end

        // R8 release sweep over the settle window
        for (int k = 0; k <= STAB + 1; k++) begin
            reach(2, 3'd0);
            stby_n = 1'b0;
            step(3);
            stby_n = 1'b1;
            step(3);
            step(k);
            res_n = 1'b1;
            step(3);
            if (k <= STAB - 3) begin
                chk("R8 early flag", early_rel, 1);
                chk("R8 no except", (state == 3) ? 1 : 0, 0);
                step(STAB + 2);
                chk("R8 stuck in ready", state, 2);
                res_n = 1'b0;
                step(3);
                res_n = 1'b1;
                step(3);
                chk("R8 fresh release", state, 3);
            end else begin
                chk("R8 timely release except", state, 3);
                chk("R8 no early flag", early_rel, 0);
            end
        end

        // R9 exit with reset already high
        reach(2, 3'd0);
        stby_n = 1'b0;
        step(3);
        res_n = 1'b1;
        step(5);
        stby_n = 1'b1;
        step(3);
        chk("R9 settle first", state, 1);
        step(STAB + 3);
        chk("R9 stays ready", state, 2);
        chk("R9 no early flag", early_rel, 0);
        res_n = 1'b0;
        step(3);
        res_n = 1'b1;
        step(3);
        chk("R9 release after low", state, 3);

        // R10 warm reset from exec
        reach(4, 3'd0);
        chk("R10 in exec", state, 4);
        res_n = 1'b0;
        step(3);
        chk("R10 ready", state, 2);
        chk("R10 func_rst", func_rst, 1);
        chk("R10 osc_en", osc_en, 1);
        res_n = 1'b1;
        step(3);
        chk("R10 direct except", state, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule